// File: doc/BRIEF.md
# Dual Programmable Interval and One-Shot Timer

This block holds two timers for a microcontroller. Both count at the system clock. A processor clock divider and a per-timer prescale set how fast they run. Software programs them through a small register bus. Writes are registered. Reads are combinational from a separate read address. Word registers use all 16 data bits. Byte registers take the low byte on write and read back zero-extended.

Timer 0 runs in one of two modes.
- **One-shot mode:** it has two independent down-counters. One counts down the count register. The other counts down a private copy of the modulus. While that one-shot runs, the modulus address reads back its remaining count.
- **Interval mode:** the count register reloads from the modulus at every period.

Timer 1 runs in interval mode only. Each expiry of Timer 1 drives two interrupt outputs in the same cycle. Timer 1 shares one of those outputs with the Timer 0 modulus one-shot.

Every period equals the value times the prescale times the divider. The prescale depends on the mode. A writes to the count register while Timer 0 is running is ignored. There is no data stream, so every pin is a plain control or status pin.

Top module: `dual_timer`

## Requirements
- R1: After reset:
  - both count registers, the Timer 0 modulus, the Timer 1 modulus and both control registers read 0;
  - the divider reads 8;
  - all three interrupt outputs are low.
- R2: Timer 0 interval mode is Timer 0 control bit 0 = 0 with bit 7 = 1.
  - `irq_cnt0` pulses for exactly one cycle every mod0 × (128 if bit 6 else 6) × divider cycles, counted from the control write edge.
  - At each pulse the Timer 0 count reads mod0 again.
- R3: Timer 0 one-shot count channel is control bit 0 = 1 with bit 7 = 1.
  - `irq_cnt0` pulses once, cnt0 × (128 if bit 6 else 12) × divider cycles after the control write.
  - The count then reads 0 and no further pulse follows.
- R4: Timer 0 one-shot modulus channel is control bit 0 = 1 with bit 5 = 1.
  - `irq_mix` pulses once, mod0 × (128 if bit 4 else 12) × divider cycles after the control write.
- R5: Every period scales linearly with the divider register. A divider value of 0 acts as 1.
- R6: A start bit whose count or modulus value is 0 starts nothing. No interrupt follows.
- R7: A control write with the start bit clear stops that timer. No interrupt follows.
- R8: Timer 1 runs when its control bit 7 = 1. Every mod1 × (128 if bit 6 else 6) × divider cycles it pulses `irq_mix` and `irq_t1` in the same cycle. The Timer 1 count reads mod1 at each pulse.
- R9: The Timer 1 control register keeps only bits 7:6. Other bits read back as 0.
- R10: Writing a nonzero Timer 1 modulus while it holds 0 starts Timer 1 from that write edge, if control bit 7 is already stored.
- R11: The Timer 0 count address reads the remaining count while counting. It reads the value written while stopped.
- R12: When the Timer 0 modulus one-shot and a Timer 1 expiry land in the same cycle, `irq_mix` gives a single one-cycle pulse.
- R13: Register addresses are:

  | Address | Register |
  |---------|----------|
  | 0 | Timer 0 count |
  | 1 | Timer 0 modulus |
  | 2 | Timer 0 control |
  | 3 | Timer 1 count (read only) |
  | 4 | Timer 1 modulus |
  | 5 | Timer 1 control |
  | 6 | divider |

  Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Write address |
| reg_wdata | input | 16 | Write data |
| reg_raddr | input | 3 | Read address |
| reg_rdata | output | 16 | Read data, combinational |
| irq_cnt0 | output | 1 | Timer 0 count/interval expiry pulse |
| irq_mix | output | 1 | Timer 0 modulus one-shot or Timer 1 expiry pulse |
| irq_t1 | output | 1 | Timer 1 expiry pulse |

## Verification
Two functions can drive `irq_mix` in the same cycle: the Timer 0 modulus one-shot and a Timer 1 expiry. The bench starts Timer 1 with a 24-cycle period. Twelve cycles later it starts a 12-cycle modulus one-shot, so both expire on the same edge. The check requires `irq_mix` and `irq_t1` high together in that cycle and `irq_mix` low in the next cycle.

// File: rtl/dual_timer_pkg.sv
package dual_timer_pkg;
  typedef enum logic [2:0] {
    AD_CNT0 = 3'd0,
    AD_MOD0 = 3'd1,
    AD_CTL0 = 3'd2,
    AD_CNT1 = 3'd3,
    AD_MOD1 = 3'd4,
    AD_CTL1 = 3'd5,
    AD_DIV  = 3'd6
  } reg_addr_e;

  localparam int unsigned NCH = 3;  // 0: T0 count, 1: T0 modulus one-shot, 2: T1
  localparam logic [7:0] PS_FAST_IV = 8'd6;
  localparam logic [7:0] PS_FAST_OS = 8'd12;
  localparam logic [7:0] PS_SLOW    = 8'd128;
endpackage

// File: rtl/dual_timer_scale.sv
module dual_timer_scale #(
  parameter int DW = 8,
  parameter int SW = DW + 8
) (
  input  logic          slow,
  input  logic [7:0]    base,
  input  logic [DW-1:0] div,
  output logic [SW-1:0] scale
);
  logic [SW-1:0] ps, dv;
  always_comb begin
    ps    = slow ? SW'(dual_timer_pkg::PS_SLOW) : SW'(base);
    dv    = (div == '0) ? SW'(1) : SW'(div);
    scale = ps * dv;
  end
endmodule

// File: rtl/dual_timer_chan.sv
module dual_timer_chan #(
  parameter int CW = 16,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [CW-1:0] ld_val,
  input  logic          halt,
  input  logic          wr_cnt,
  input  logic [CW-1:0] wr_val,
  input  logic          reload_en,
  input  logic [CW-1:0] reload_val,
  input  logic [SW-1:0] scale,
  output logic [CW-1:0] cnt,
  output logic          busy,
  output logic          fire
);
  logic [SW-1:0] sub;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      sub  <= '0;
      busy <= 1'b0;
      fire <= 1'b0;
    end else begin
      fire <= 1'b0;
      if (ld) begin
        cnt  <= ld_val;
        sub  <= '0;
        busy <= 1'b1;
      end else if (halt) begin
        busy <= 1'b0;
        sub  <= '0;
      end else if (busy) begin
        if (sub >= scale - SW'(1)) begin
          sub <= '0;
          if (cnt == CW'(1)) begin
            fire <= 1'b1;
            if (reload_en && reload_val != '0) begin
              cnt <= reload_val;
            end else begin
              cnt  <= '0;
              busy <= 1'b0;
            end
          end else begin
            cnt <= cnt - CW'(1);
          end
        end else begin
          sub <= sub + SW'(1);
        end
      end else if (wr_cnt) begin
        cnt <= wr_val;
      end
    end
  end

  // R2
  fire_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> $past(busy));

  // R6
  run_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cnt != '0);

  // R3
  oneshot_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !$past(reload_en)) |-> !busy);
endmodule

// File: rtl/dual_timer.sv
module dual_timer #(
  parameter int CW = 16,
  parameter int DW = 8,
  parameter logic [DW-1:0] DIV_RST = DW'(8)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_waddr,
  input  logic [15:0]   reg_wdata,
  input  logic [2:0]    reg_raddr,
  output logic [15:0]   reg_rdata,
  output logic          irq_cnt0,
  output logic          irq_mix,
  output logic          irq_t1
);
  import dual_timer_pkg::*;
  localparam int SW = DW + 8;

  logic [CW-1:0] mod0_q, mod1_q;
  logic [7:0]    ctl0_q;
  logic [1:0]    ctl1_q;
  logic [DW-1:0] div_q;

  logic [NCH-1:0] ld, halt, wrc, rel_en, fire, busy, slow;
  logic [CW-1:0]  ldv  [NCH];
  logic [CW-1:0]  relv [NCH];
  logic [CW-1:0]  cnt  [NCH];
  logic [SW-1:0]  scl  [NCH];
  logic [7:0]     base [NCH];

  logic [7:0] wb;
  logic       w_ctl0, w_ctl1, w_mod1, w_cnt0;
  assign wb     = reg_wdata[7:0];
  assign w_ctl0 = reg_we && reg_waddr == AD_CTL0;
  assign w_ctl1 = reg_we && reg_waddr == AD_CTL1;
  assign w_mod1 = reg_we && reg_waddr == AD_MOD1;
  assign w_cnt0 = reg_we && reg_waddr == AD_CNT0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mod0_q <= '0;
      mod1_q <= '0;
      ctl0_q <= '0;
      ctl1_q <= '0;
      div_q  <= DIV_RST;
    end else if (reg_we) begin
      case (reg_waddr)
        AD_MOD0: mod0_q <= reg_wdata[CW-1:0];
        AD_MOD1: mod1_q <= reg_wdata[CW-1:0];
        AD_CTL0: ctl0_q <= wb;
        AD_CTL1: ctl1_q <= wb[7:6];
        AD_DIV:  div_q  <= wb[DW-1:0];
        default: ;
      endcase
    end
  end

  // start/stop decisions, evaluated on the write that changes them
  always_comb begin
    ld   = '0;
    halt = '0;
    ldv[0] = wb[0] ? cnt[0] : mod0_q;
    ldv[1] = mod0_q;
    ldv[2] = w_mod1 ? reg_wdata[CW-1:0] : mod1_q;
    if (w_ctl0) begin
      if (wb[7] && ldv[0] != '0) ld[0] = 1'b1;
      else                       halt[0] = 1'b1;
      if (wb[0] && wb[5] && mod0_q != '0) ld[1] = 1'b1;
      else                                halt[1] = 1'b1;
    end
    if (w_ctl1) begin
      if (wb[7] && mod1_q != '0) ld[2] = 1'b1;
      else                       halt[2] = 1'b1;
    end else if (w_mod1 && mod1_q == '0 && reg_wdata[CW-1:0] != '0 && ctl1_q[1]) begin
      ld[2] = 1'b1;
    end
  end

  always_comb begin
    wrc     = {2'b00, w_cnt0};
    rel_en  = {1'b1, 1'b0, !ctl0_q[0]};
    relv[0] = mod0_q;
    relv[1] = '0;
    relv[2] = mod1_q;
    slow    = {ctl1_q[0], ctl0_q[4], ctl0_q[6]};
    base[0] = ctl0_q[0] ? PS_FAST_OS : PS_FAST_IV;
    base[1] = PS_FAST_OS;
    base[2] = PS_FAST_IV;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dual_timer_scale #(.DW(DW), .SW(SW)) scale_i (
      .slow(slow[g]), .base(base[g]), .div(div_q), .scale(scl[g]));
    dual_timer_chan #(.CW(CW), .SW(SW)) chan_i (
      .clk(clk), .rst_n(rst_n), .ld(ld[g]), .ld_val(ldv[g]),
      .halt(halt[g]), .wr_cnt(wrc[g]), .wr_val(reg_wdata[CW-1:0]),
      .reload_en(rel_en[g]), .reload_val(relv[g]), .scale(scl[g]),
      .cnt(cnt[g]), .busy(busy[g]), .fire(fire[g]));
  end

  assign irq_cnt0 = fire[0];
  assign irq_mix  = fire[1] | fire[2];
  assign irq_t1   = fire[2];

  always_comb begin
    case (reg_raddr)
      AD_CNT0: reg_rdata = 16'(cnt[0]);
      AD_MOD0: reg_rdata = 16'(busy[1] ? cnt[1] : mod0_q);
      AD_CTL0: reg_rdata = {8'h00, ctl0_q};
      AD_CNT1: reg_rdata = 16'(cnt[2]);
      AD_MOD1: reg_rdata = 16'(mod1_q);
      AD_CTL1: reg_rdata = {8'h00, ctl1_q, 6'b0};
      AD_DIV:  reg_rdata = 16'(div_q);
      default: reg_rdata = '0;
    endcase
  end

  // R8
  t1_irq_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_t1 |-> ctl1_q[1]);

  // R4
  mod_os_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy[1] |-> ctl0_q[0]);
endmodule

// File: tb/dual_timer_tb_top.sv
module dual_timer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_waddr = '0, reg_raddr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic irq_cnt0, irq_mix, irq_t1;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dual_timer dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .irq_cnt0(irq_cnt0), .irq_mix(irq_mix), .irq_t1(irq_t1));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int d);
    reg_raddr = a;
    #1;
    d = int'(reg_rdata);
  endtask

  // sel: 0 irq_cnt0, 1 irq_mix, 2 irq_t1, 3 cnt0 or mix; k = edges to pulse, 0 if none
  task automatic wait_irq(input int sel, input int lim, output int k);
    bit hit;
    hit = 1'b0;
    k = 0;
    for (int i = 1; i <= lim && !hit; i++) begin
      @(posedge clk);
      @(negedge clk);
      case (sel)
        0: hit = irq_cnt0;
        1: hit = irq_mix;
        2: hit = irq_t1;
        default: hit = irq_cnt0 | irq_mix;
      endcase
      if (hit) k = i;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int v, k, ps;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 R13 reset values
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk("R1 R13 reset read", v, (a == 6) ? 8 : 0);
    end
    chk("R1 irq low", int'({irq_cnt0, irq_mix, irq_t1}), 0);
    wr(3'd6, 16'd1);

    // R11 write while stopped
    wr(3'd0, 16'h1234);
    rd(3'd0, v); chk("R11 count write", v, 'h1234);

    // R2 interval sweep
    for (int n = 1; n <= 3; n++) begin
      for (int s = 0; s < 2; s++) begin
        ps = s ? 128 : 6;
        wr(3'd1, 16'(n));
        wr(3'd2, 16'(8'h80 | (s << 6)));
        wait_irq(0, n * ps + 5, k); chk("R2 first period", k, n * ps);
        wait_irq(0, n * ps + 5, k); chk("R2 second period", k, n * ps);
        rd(3'd0, v); chk("R2 reload", v, n);
        wr(3'd2, 16'h0000);
      end
    end
    // R7 stopped stays silent
    wait_irq(0, 60, k); chk("R7 stop", k, 0);

    // R3 one-shot count sweep
    for (int n = 1; n <= 3; n++) begin
      for (int s = 0; s < 2; s++) begin
        ps = s ? 128 : 12;
        wr(3'd0, 16'(n));
        wr(3'd2, 16'(8'h81 | (s << 6)));
        wait_irq(0, n * ps + 5, k); chk("R3 one-shot", k, n * ps);
        rd(3'd0, v); chk("R3 count zero", v, 0);
        wait_irq(0, 2 * n * ps, k); chk("R3 no repeat", k, 0);
      end
    end

    // R11 remaining count mid-run
    wr(3'd0, 16'd5);
    wr(3'd2, 16'h0081);
    repeat (24) @(negedge clk);
    rd(3'd0, v); chk("R11 remaining", v, 3);
    wait_irq(0, 50, k); chk("R11 rest", k, 36);

    // R4 modulus one-shot sweep
    for (int n = 1; n <= 2; n++) begin
      for (int s = 0; s < 2; s++) begin
        ps = s ? 128 : 12;
        wr(3'd1, 16'(n));
        wr(3'd2, 16'(8'h21 | (s << 4)));
        wait_irq(1, n * ps + 5, k); chk("R4 modulus one-shot", k, n * ps);
      end
    end
    wait_irq(1, 300, k); chk("R4 no repeat", k, 0);

    // R6 zero values never start
    wr(3'd2, 16'h0000);
    wr(3'd1, 16'h0000);
    wr(3'd2, 16'h0080);
    wait_irq(3, 100, k); chk("R6 zero modulus interval", k, 0);
    wr(3'd0, 16'h0000);
    wr(3'd2, 16'h00A1);
    wait_irq(3, 100, k); chk("R6 zero one-shot", k, 0);

    // R5 divider scaling
    wr(3'd2, 16'h0000);
    wr(3'd6, 16'd8);
    wr(3'd1, 16'd2);
    wr(3'd2, 16'h0080);
    wait_irq(0, 120, k); chk("R5 divider 8", k, 96);
    wr(3'd2, 16'h0000);
    wr(3'd6, 16'd0);
    wr(3'd2, 16'h0080);
    wait_irq(0, 30, k); chk("R5 divider 0 as 1", k, 12);
    wr(3'd2, 16'h0000);
    wr(3'd6, 16'd1);

    // R9 control masking, R10 modulus-triggered start, R8 dual pulse
    wr(3'd5, 16'h00FF);
    rd(3'd5, v); chk("R9 ctl1 mask", v, 'hC0);
    wait_irq(2, 50, k); chk("R6 T1 zero modulus", k, 0);
    wr(3'd5, 16'h0080);
    wr(3'd4, 16'd3);
    wait_irq(2, 30, k); chk("R10 start on modulus", k, 18);
    chk("R8 mix with t1", int'(irq_mix), 1);
    wait_irq(2, 30, k); chk("R8 period", k, 18);
    chk("R8 mix with t1 again", int'(irq_mix), 1);
    rd(3'd3, v); chk("R8 count reload", v, 3);
    wr(3'd5, 16'h0000);
    wait_irq(2, 40, k); chk("R7 T1 stop", k, 0);

    // R12 coincident sources on irq_mix
    wr(3'd4, 16'd4);
    wr(3'd1, 16'd1);
    wr(3'd5, 16'h0080);
    repeat (10) @(negedge clk);
    wr(3'd2, 16'h0021);
    wait_irq(1, 20, k); chk("R12 coincide edge", k, 12);
    chk("R12 t1 same cycle", int'(irq_t1), 1);
    @(posedge clk); @(negedge clk);
    chk("R12 single pulse", int'(irq_mix), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule